// File: doc/BRIEF.md
# Doorbell Interrupt Unit

The doorbell unit gives each of up to four processors a private set of 32 doorbell flags and a matching enable set. Any bus master can raise flags through one shared trigger register: a single write names a doorbell number and a bitmap of destination processors. A processor sending an inter-processor interrupt uses this register, and so does a PCIe MSI write aimed at its address.

Each processor has a banked window holding its flag (cause) register and its enable (mask) register. Software acknowledges a flag by writing zero to that bit. Writing one leaves the bit as it is, so the usual acknowledge value is the complement of the bit being cleared.

The flags that are set and enabled drive two summary lines per processor. Doorbells 0 to 7 are inter-processor interrupts and drive one line. Doorbells 16 to 31 are the sixteen MSI vectors and drive the other line. A downstream interrupt controller reads these lines as two of its sources.

Top module: `dbell_unit`

## Requirements
- R1: After reset every cause register and every mask register is zero, and all summary lines are low.
- R2: A global write to offset 0x04 sets cause bit d of each processor c whose bit (8+c) in the written data is 1. The doorbell number d is taken from data bits 4:0. Processors whose map bit is 0 are unchanged. The result is visible one cycle after the write.
- R3: A trigger whose doorbell number is between 8 and 15 changes nothing. Map bits above bit (8+NCPU-1) are ignored. Cause bits 8 to 15 always read as zero.
- R4: A banked write to offset 0x08 of processor c clears every cause bit where the data is 0 and leaves every bit where the data is 1.
- R5: When a trigger and a cause-clear write reach the same bit in the same cycle, the bit ends up set.
- R6: A banked write to offset 0x0C of processor c replaces that processor's 32-bit mask.
- R7: The inter-processor line of processor c is high exactly while (cause & mask) bits 7:0 of that processor are non-zero.
- R8: The MSI line of processor c is high exactly while (cause & mask) bits 31:16 of that processor are non-zero.
- R9: A trigger write with data 0xF00 | (16+n), for n from 0 to 15, sets bit 16+n in all four processors.
- R10: Global writes to any offset other than 0x04, and banked writes to any offset other than 0x08 and 0x0C, change no state.
- R11: A banked write affects only the processor selected by its processor index. The readback outputs show the cause and mask of the processor chosen by `rd_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_wr_en | input | 1 | Global register write strobe |
| glb_wr_addr | input | ADDR_W | Global write offset |
| glb_wr_data | input | 32 | Global write data |
| cpu_wr_en | input | 1 | Banked register write strobe |
| cpu_wr_id | input | CPU_IDX_W | Processor whose bank is written |
| cpu_wr_addr | input | ADDR_W | Banked write offset |
| cpu_wr_data | input | 32 | Banked write data |
| rd_id | input | CPU_IDX_W | Processor whose registers are shown on the readback outputs |
| rd_cause | output | 32 | Cause register of the selected processor |
| rd_mask | output | 32 | Mask register of the selected processor |
| ipi_irq | output | NCPU | Inter-processor summary line, one per processor |
| msi_irq | output | NCPU | MSI summary line, one per processor |

## Verification
Every write lands in a register at the first rising edge after its strobe. The readback outputs and the summary lines are combinational from those registers, so every result is due exactly one cycle after the stimulus. The bench drives each strobe on a falling edge and drops it on the next falling edge. It compares all four processors' cause, mask and summary lines against its arithmetic model at that second falling edge, when the edge in between has already taken the write. The same-cycle case drives both strobes on one falling edge, so both writes meet at a single rising edge.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
   localparam int DB_W    = 32;
   localparam int NUM_W   = 5;
   localparam int MAP_LSB = 8;
   localparam int MAX_CPU = 4;
   localparam int IPI_LO  = 0;
   localparam int IPI_N   = 8;
   localparam int MSI_LO  = 16;
   localparam int MSI_N   = 16;

   typedef logic [DB_W-1:0] db_vec_t;

   function automatic db_vec_t live_bits();
      db_vec_t v;
      v = '0;
      for (int i = 0; i < DB_W; i++)
         if ((i >= IPI_LO && i < IPI_LO + IPI_N) || (i >= MSI_LO && i < MSI_LO + MSI_N))
            v[i] = 1'b1;
      return v;
   endfunction

   localparam db_vec_t DB_LIVE = live_bits();
endpackage

// File: rtl/dbell_trig_dec.sv
module dbell_trig_dec
   import dbell_pkg::*;
#(
   parameter int NCPU = 4,
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] TRIG_OFS = 'h04
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  db_vec_t           wr_data,
   output db_vec_t           set_vec [NCPU]
);
   generate
      if (NCPU < 1 || NCPU > MAX_CPU) begin : g_bad_ncpu
         $error("dbell_trig_dec: NCPU out of range");
      end
      if (MAP_LSB + NCPU > DB_W) begin : g_bad_map
         $error("dbell_trig_dec: map field exceeds data width");
      end
   endgenerate

   logic            hit;
   logic [NUM_W-1:0] num;
   db_vec_t         bit_sel;

   assign hit     = wr_en && (wr_addr == TRIG_OFS);
   assign num     = wr_data[NUM_W-1:0];
   // only implemented doorbells survive; numbers in the hole are dropped
   assign bit_sel = (db_vec_t'(1) << num) & DB_LIVE;

   generate
      for (genvar c = 0; c < NCPU; c++) begin : g_tgt
         assign set_vec[c] = (hit && wr_data[MAP_LSB+c]) ? bit_sel : '0;
      end
   endgenerate
endmodule

// File: rtl/dbell_cpu_bank.sv
module dbell_cpu_bank
   import dbell_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] CAUSE_OFS = 'h08,
   parameter logic [ADDR_W-1:0] MASK_OFS  = 'h0C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  db_vec_t           set_vec,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  db_vec_t           wr_data,
   output db_vec_t           cause,
   output db_vec_t           mask
);
   generate
      if (CAUSE_OFS == MASK_OFS) begin : g_bad_ofs
         $error("dbell_cpu_bank: cause and mask offsets collide");
      end
   endgenerate

   logic    clr_hit;
   logic    mask_hit;
   db_vec_t cause_kept;
   db_vec_t cause_nxt;

   assign clr_hit    = wr_en && (wr_addr == CAUSE_OFS);
   assign mask_hit   = wr_en && (wr_addr == MASK_OFS);
   assign cause_kept = clr_hit ? (cause & wr_data) : cause;
   // set is applied after the clear so a same-cycle trigger wins
   assign cause_nxt  = (cause_kept | set_vec) & DB_LIVE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause <= '0;
         mask  <= '0;
      end else begin
         cause <= cause_nxt;
         if (mask_hit)
            mask <= wr_data;
      end
   end

   a_r5_trigger_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((cause & $past(set_vec)) == $past(set_vec)));

   a_r4_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit |=> ((cause & ~$past(wr_data) & ~$past(set_vec)) == '0));

   a_r3_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause & ~DB_LIVE) == '0));

   a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_hit |=> $stable(mask));
endmodule

// File: rtl/dbell_summary.sv
module dbell_summary
   import dbell_pkg::*;
#(
   parameter int NCPU = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  db_vec_t         cause [NCPU],
   input  db_vec_t         mask  [NCPU],
   output logic [NCPU-1:0] ipi_irq,
   output logic [NCPU-1:0] msi_irq
);
   generate
      for (genvar c = 0; c < NCPU; c++) begin : g_sum
         db_vec_t live;
         assign live       = cause[c] & mask[c];
         assign ipi_irq[c] = |live[IPI_LO +: IPI_N];
         assign msi_irq[c] = |live[MSI_LO +: MSI_N];

         a_r7_ipi_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
            ipi_irq[c] |-> (mask[c][IPI_LO +: IPI_N] != '0));
         a_r7_ipi_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
            (cause[c][IPI_LO +: IPI_N] == '0) |-> !ipi_irq[c]);
         a_r8_msi_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
            msi_irq[c] |-> (mask[c][MSI_LO +: MSI_N] != '0));
         a_r8_msi_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
            (cause[c][MSI_LO +: MSI_N] == '0) |-> !msi_irq[c]);
      end
   endgenerate
endmodule

// File: rtl/dbell_unit.sv
module dbell_unit
   import dbell_pkg::*;
#(
   parameter int NCPU = 4,
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] TRIG_OFS  = 'h04,
   parameter logic [ADDR_W-1:0] CAUSE_OFS = 'h08,
   parameter logic [ADDR_W-1:0] MASK_OFS  = 'h0C,
   localparam int CPU_IDX_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 glb_wr_en,
   input  logic [ADDR_W-1:0]    glb_wr_addr,
   input  logic [31:0]          glb_wr_data,
   input  logic                 cpu_wr_en,
   input  logic [CPU_IDX_W-1:0] cpu_wr_id,
   input  logic [ADDR_W-1:0]    cpu_wr_addr,
   input  logic [31:0]          cpu_wr_data,
   input  logic [CPU_IDX_W-1:0] rd_id,
   output logic [31:0]          rd_cause,
   output logic [31:0]          rd_mask,
   output logic [NCPU-1:0]      ipi_irq,
   output logic [NCPU-1:0]      msi_irq
);
   localparam logic [CPU_IDX_W:0] NCPU_V = NCPU[CPU_IDX_W:0];

   db_vec_t set_a   [NCPU];
   db_vec_t cause_a [NCPU];
   db_vec_t mask_a  [NCPU];

   dbell_trig_dec #(.NCPU(NCPU), .ADDR_W(ADDR_W), .TRIG_OFS(TRIG_OFS)) trig_i (
      .wr_en   (glb_wr_en),
      .wr_addr (glb_wr_addr),
      .wr_data (glb_wr_data),
      .set_vec (set_a)
   );

   generate
      for (genvar c = 0; c < NCPU; c++) begin : g_bank
         logic sel_we;
         assign sel_we = cpu_wr_en && (cpu_wr_id == CPU_IDX_W'(c));

         dbell_cpu_bank #(.ADDR_W(ADDR_W), .CAUSE_OFS(CAUSE_OFS), .MASK_OFS(MASK_OFS)) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_vec (set_a[c]),
            .wr_en   (sel_we),
            .wr_addr (cpu_wr_addr),
            .wr_data (cpu_wr_data),
            .cause   (cause_a[c]),
            .mask    (mask_a[c])
         );

         a_r11_bank_private: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel_we && set_a[c] == '0) |=> $stable(cause_a[c]) && $stable(mask_a[c]));
      end
   endgenerate

   dbell_summary #(.NCPU(NCPU)) sum_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cause   (cause_a),
      .mask    (mask_a),
      .ipi_irq (ipi_irq),
      .msi_irq (msi_irq)
   );

   logic rd_ok;
   assign rd_ok    = ({1'b0, rd_id} < NCPU_V);
   assign rd_cause = rd_ok ? cause_a[rd_id] : '0;
   assign rd_mask  = rd_ok ? mask_a[rd_id]  : '0;
endmodule

// File: tb/dbell_unit_tb_top.sv
`timescale 1ns/1ps
module dbell_unit_tb_top;
   localparam int NC = 4;
   localparam logic [7:0] A_TRIG = 8'h04;
   localparam logic [7:0] A_CAUSE = 8'h08;
   localparam logic [7:0] A_MASK = 8'h0C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        glb_wr_en = 1'b0;
   logic [7:0]  glb_wr_addr = '0;
   logic [31:0] glb_wr_data = '0;
   logic        cpu_wr_en = 1'b0;
   logic [1:0]  cpu_wr_id = '0;
   logic [7:0]  cpu_wr_addr = '0;
   logic [31:0] cpu_wr_data = '0;
   logic [1:0]  rd_id = '0;
   logic [31:0] rd_cause, rd_mask;
   logic [NC-1:0] ipi_irq, msi_irq;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [31:0] m_cause [NC];
   logic [31:0] m_mask  [NC];

   always #2.5 clk = ~clk;

   dbell_unit #(.NCPU(NC)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .glb_wr_en(glb_wr_en), .glb_wr_addr(glb_wr_addr), .glb_wr_data(glb_wr_data),
      .cpu_wr_en(cpu_wr_en), .cpu_wr_id(cpu_wr_id), .cpu_wr_addr(cpu_wr_addr),
      .cpu_wr_data(cpu_wr_data), .rd_id(rd_id), .rd_cause(rd_cause), .rd_mask(rd_mask),
      .ipi_irq(ipi_irq), .msi_irq(msi_irq)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // model of a trigger write
   function automatic void m_trig(logic [31:0] d);
      int n = int'(d[4:0]);
      if (n < 8 || n >= 16)
         for (int c = 0; c < NC; c++)
            if (d[8+c]) m_cause[c][n] = 1'b1;
   endfunction

   task automatic verify(string tag);
      for (int c = 0; c < NC; c++) begin
         logic [31:0] live;
         rd_id = 2'(c);
         #0.5;
         live = m_cause[c] & m_mask[c];
         chk({tag, " cause"}, rd_cause, m_cause[c]);
         chk({tag, " mask"}, rd_mask, m_mask[c]);
         chk({tag, " R7 ipi"}, 32'(ipi_irq[c]), 32'(|live[7:0]));
         chk({tag, " R8 msi"}, 32'(msi_irq[c]), 32'(|live[31:16]));
      end
   endtask

   task automatic glb_wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      glb_wr_en = 1'b1; glb_wr_addr = a; glb_wr_data = d;
      @(negedge clk);
      glb_wr_en = 1'b0;
   endtask

   task automatic cpu_wr(int id, logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      cpu_wr_en = 1'b1; cpu_wr_id = 2'(id); cpu_wr_addr = a; cpu_wr_data = d;
      @(negedge clk);
      cpu_wr_en = 1'b0;
   endtask

   task automatic clear_all();
      for (int c = 0; c < NC; c++) begin
         cpu_wr(c, A_CAUSE, 32'h0);
         m_cause[c] = '0;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < NC; c++) begin m_cause[c] = '0; m_mask[c] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      verify("R1 reset");

      // masks: R6 write and R11 isolation
      cpu_wr(0, A_MASK, 32'hFFFF_FFFF); m_mask[0] = 32'hFFFF_FFFF; verify("R6 R11 mask0");
      cpu_wr(1, A_MASK, 32'h0000_00FF); m_mask[1] = 32'h0000_00FF; verify("R6 R11 mask1");
      cpu_wr(3, A_MASK, 32'hFFFF_0000); m_mask[3] = 32'hFFFF_0000; verify("R6 R11 mask3");

      // sweep every doorbell number against every map, with noise in ignored bits
      for (int d = 0; d < 32; d++) begin
         for (int mp = 0; mp < 16; mp++) begin
            logic [31:0] w;
            w = {16'hA5C3, 4'(mp ^ 15), 4'(mp), 3'(d ^ 5), 5'(d)};
            glb_wr(A_TRIG, w);
            m_trig(w);
            verify((d >= 8 && d < 16) ? "R3 hole" : "R2 trigger");
            clear_all();
         end
      end

      // partial acknowledge by complement
      for (int k = 0; k < 4; k++) begin glb_wr(A_TRIG, 32'h100 | 32'(k)); m_trig(32'h100 | 32'(k)); end
      glb_wr(A_TRIG, 32'h0000_0113); m_trig(32'h0000_0113);
      cpu_wr(0, A_CAUSE, ~(32'h1 << 2)); m_cause[0][2] = 1'b0;
      verify("R4 ack one");
      cpu_wr(0, A_CAUSE, 32'hFFFF_FFF0); m_cause[0] &= 32'hFFFF_FFF0;
      verify("R4 ack low nibble");

      // same-cycle trigger and clear on CPU 0
      @(negedge clk);
      glb_wr_en = 1'b1; glb_wr_addr = A_TRIG; glb_wr_data = 32'h0000_0105;
      cpu_wr_en = 1'b1; cpu_wr_id = 2'd0; cpu_wr_addr = A_CAUSE; cpu_wr_data = 32'h0;
      @(negedge clk);
      glb_wr_en = 1'b0; cpu_wr_en = 1'b0;
      m_cause[0] = 32'h0000_0020;
      verify("R5 collide");
      clear_all();

      // MSI-style writes
      for (int n = 0; n < 16; n++) begin
         glb_wr(A_TRIG, 32'hF00 | 32'(16 + n));
         m_trig(32'hF00 | 32'(16 + n));
         verify("R9 msi");
      end

      // writes to unused offsets
      glb_wr(A_CAUSE, 32'h0000_0F05); verify("R10 global offset");
      glb_wr(8'h00, 32'h0000_0F11); verify("R10 global zero");
      cpu_wr(2, A_TRIG, 32'h0); verify("R10 bank offset");
      cpu_wr(1, 8'h10, 32'h0); verify("R10 bank other");

      // acknowledge on one CPU leaves the others
      cpu_wr(2, A_CAUSE, 32'h0); m_cause[2] = '0; verify("R11 private clear");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule